// File: doc/BRIEF.md
# Parallel Converter Read Sequencer

This block is the host-side master for a successive-approximation converter with a 14-bit parallel output bus, an active-low chip select, a read/convert select line and an active-low end-of-conversion flag. Each pulse on the start input runs one complete conversion frame. The frame has three chip-select falling edges. The first starts acquisition. The second starts conversion and, through the level of the read/convert line, tells the converter whether to keep its reference powered (standby) or to power it down (shutdown) once the conversion ends. The third edge enables the converter's data outputs, and the block then captures the bus.

All converter timing limits are clock-cycle parameters. These cover the chip-select low and high widths, the acquisition window, the data-valid delay, the bus release gap and the long reference wake-up window. The block tracks whether the converter's reference is powered. When it is not, the block stretches the acquisition window until the reference has settled. A captured code can be passed on as straight binary or, for bipolar input ranges, turned from offset binary into two's complement. The result comes out with a one-cycle valid strobe. If the end-of-conversion flag never falls, a timeout pulse ends the frame.

Top module: `adc_read_ctrl`

## Requirements
- R1: Every frame makes exactly three chip-select falling edges. The read/convert line is low on the first edge. On the second edge it equals the shutdown choice latched at start (1 = power the reference down after conversion, 0 = keep it up). It is high on the third edge.
- R2: Chip select stays low for at least T_CSL cycles and high for at least T_CSH cycles between any two of its transitions.
- R3: When the reference is known to be powered (the previous frame chose standby), the second edge comes exactly T_ACQ cycles after the first edge.
- R4: When the reference may be unpowered (the first frame after reset, a frame after a shutdown choice, or a frame after a timeout), the second edge comes exactly max(T_ACQ, T_WAKE) cycles after the first edge.
- R5: The third edge is issued only after the end-of-conversion input has gone low. The bus is captured only once chip select has been low for more than T_DO cycles.
- R6: A first edge comes no sooner than T_BR cycles after chip select rises at the end of a read.
- R7: With bipolar mode latched at start, the result equals the captured code with its most significant bit (bit 13) inverted, which is two's complement. Otherwise the result equals the captured code.
- R8: valid_o is high for exactly one cycle per completed frame, and busy_o is low in that cycle. busy_o is high from the cycle after an accepted start until the strobe.
- R9: A start pulse that arrives while busy_o is high has no effect, and neither do the mode inputs presented with it. A start pulse in the strobe cycle is accepted.
- R10: If end-of-conversion has not fallen T_TMO cycles after the conversion wait begins, timeout_o pulses for one cycle, T_CSL + T_TMO cycles after the second edge. No strobe is produced, busy_o drops, and the reference is then treated as unpowered.
- R11: Out of reset, chip select is high and busy_o, valid_o and timeout_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request one conversion frame |
| bipolar_i | input | 1 | Offset-binary to two's-complement conversion for this frame |
| shutdown_i | input | 1 | Power the reference down after this frame's conversion |
| eoc_n_i | input | 1 | End-of-conversion flag from the converter, low when data is ready |
| data_i | input | DW (14) | Converter parallel output bus |
| cs_n_o | output | 1 | Converter chip select, active low |
| rc_o | output | 1 | Converter read/convert select |
| result_o | output | DW (14) | Formatted result, held until the next capture |
| valid_o | output | 1 | One-cycle result strobe |
| busy_o | output | 1 | Frame in progress |
| timeout_o | output | 1 | One-cycle pulse when end-of-conversion never arrives |

## Verification
The result strobe and the acceptance of a new start can fall in the same cycle. The bench issues each next start in the very cycle valid_o is seen, so frames run back to back. A converter model then judges the release gap, the chip-select widths and the exact edge spacing of the following frame. Extra start pulses with inverted mode inputs are injected mid-frame, and they are judged by the count of first edges and by the format of the results. A silenced end-of-conversion is used to check that the timeout pulse and a strobe never coincide, and that the frame after it waits the full wake-up window.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,    // waiting for start
      ST_ARM,     // bus release gap before the first edge
      ST_PICK,    // first low pulse: acquisition begins
      ST_TRACK,   // acquisition window, mode level on rc
      ST_HOLD,    // second low pulse: conversion begins
      ST_WAIT,    // waiting for end of conversion
      ST_READ     // third low pulse: data on the bus
   } rd_state_t;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/adc_rd_timer.sv
module adc_rd_timer #(
   parameter int MAX           = 4,
   parameter bit FULL_AT_RESET = 1'b0,
   parameter int W             = $clog2(MAX + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   output logic [W-1:0] cnt_o
);

   localparam logic [W-1:0] TOP = W'(MAX);

   generate
      if (MAX < 1) begin : g_bad_max
         $error("adc_rd_timer: MAX must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_o <= FULL_AT_RESET ? TOP : '0;
      end else if (clr_i) begin
         cnt_o <= '0;
      end else if (cnt_o != TOP) begin
         cnt_o <= cnt_o + 1'b1;
      end
   end

   // edge spacing (R3) depends on the count never wrapping past its ceiling
   assert_timer_sat_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cnt_o) == TOP && !$past(clr_i)) |-> cnt_o == TOP);

endmodule

// File: rtl/adc_rd_fmt.sv
module adc_rd_fmt #(
   parameter int DW = 14
) (
   input  logic          bipolar_i,
   input  logic [DW-1:0] code_i,
   output logic [DW-1:0] res_o
);

   generate
      if (DW < 2) begin : g_bad_width
         $error("adc_rd_fmt: DW must be at least 2");
      end
      if (DW >= 2) begin : g_split
         // offset binary to two's complement: flip only the top bit
         assign res_o = {code_i[DW-1] ^ bipolar_i, code_i[DW-2:0]};
      end else begin : g_flat
         assign res_o = code_i ^ {DW{bipolar_i}};
      end
   endgenerate

endmodule

// File: rtl/adc_read_ctrl.sv
module adc_read_ctrl import adc_rd_pkg::*; #(
   parameter int DW     = 14,
   parameter int T_CSL  = 4,
   parameter int T_CSH  = 4,
   parameter int T_ACQ  = 100,
   parameter int T_WAKE = 600000,
   parameter int T_DO   = 4,
   parameter int T_BR   = 4,
   parameter int T_TMO  = 300
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          bipolar_i,
   input  logic          shutdown_i,
   input  logic          eoc_n_i,
   input  logic [DW-1:0] data_i,
   output logic          cs_n_o,
   output logic          rc_o,
   output logic [DW-1:0] result_o,
   output logic          valid_o,
   output logic          busy_o,
   output logic          timeout_o
);

   localparam int GAP_MIN = max2(T_BR, T_CSH);
   localparam int RD_LEN  = max2(T_DO + 1, T_CSL);
   localparam int ACQ_OFF = max2(T_ACQ, T_WAKE);
   localparam int PH_MAX  = max2(max2(T_CSL, T_CSH), max2(RD_LEN, T_TMO));
   localparam int RUN_MAX = max2(T_CSL, T_CSH);
   localparam int PW      = $clog2(PH_MAX + 1);
   localparam int AW      = $clog2(ACQ_OFF + 1);
   localparam int GW      = $clog2(GAP_MIN + 1);
   localparam int RW      = $clog2(RUN_MAX + 1);

   localparam logic [PW-1:0] CSL_M1  = PW'(T_CSL - 1);
   localparam logic [PW-1:0] CSH_M1  = PW'(T_CSH - 1);
   localparam logic [PW-1:0] RD_M1   = PW'(RD_LEN - 1);
   localparam logic [PW-1:0] TMO_M1  = PW'(T_TMO - 1);
   localparam logic [AW-1:0] ACQ_M1  = AW'(T_ACQ - 1);
   localparam logic [AW-1:0] OFF_M1  = AW'(ACQ_OFF - 1);
   localparam logic [GW-1:0] GAP_M1  = GW'(GAP_MIN - 1);
   localparam logic [RW-1:0] RUN_TOP = RW'(RUN_MAX);
   localparam logic [RW-1:0] RCSL_M1 = RW'(T_CSL - 1);
   localparam logic [RW-1:0] RCSH_M1 = RW'(T_CSH - 1);

   generate
      if (DW < 2) begin : g_bad_dw
         $error("adc_read_ctrl: DW must be at least 2");
      end
      if (T_CSL < 1 || T_CSH < 1 || T_DO < 0 || T_BR < 1) begin : g_bad_pulse
         $error("adc_read_ctrl: pulse and gap widths must be positive");
      end
      if (T_ACQ < T_CSL + T_CSH) begin : g_bad_acq
         $error("adc_read_ctrl: T_ACQ must cover one low and one high pulse");
      end
      if (T_TMO <= T_CSH) begin : g_bad_tmo
         $error("adc_read_ctrl: T_TMO must exceed T_CSH");
      end
   endgenerate

   rd_state_t       state_q, state_d;
   logic            pd_q, bip_q, ref_off_q;
   logic [DW-1:0]   res_q;
   logic [DW-1:0]   fmt_res;
   logic            valid_q, tmo_q;
   logic            cap_evt, tmo_evt;
   logic [PW-1:0]   ph_cnt;
   logic [AW-1:0]   acq_cnt;
   logic [GW-1:0]   gap_cnt;
   logic [AW-1:0]   need_m1;
   logic            ph_clr, acq_clr, gap_clr;

   // timers: phase within a state, distance from the first edge, release gap
   adc_rd_timer #(.MAX(PH_MAX), .FULL_AT_RESET(1'b0), .W(PW)) u_ph_tmr (
      .clk(clk), .rst_n(rst_n), .clr_i(ph_clr), .cnt_o(ph_cnt));

   adc_rd_timer #(.MAX(ACQ_OFF), .FULL_AT_RESET(1'b0), .W(AW)) u_acq_tmr (
      .clk(clk), .rst_n(rst_n), .clr_i(acq_clr), .cnt_o(acq_cnt));

   adc_rd_timer #(.MAX(GAP_MIN), .FULL_AT_RESET(1'b1), .W(GW)) u_gap_tmr (
      .clk(clk), .rst_n(rst_n), .clr_i(gap_clr), .cnt_o(gap_cnt));

   adc_rd_fmt #(.DW(DW)) u_fmt (
      .bipolar_i(bip_q), .code_i(data_i), .res_o(fmt_res));

   assign need_m1 = ref_off_q ? OFF_M1 : ACQ_M1;

   always_comb begin
      state_d = state_q;
      cap_evt = 1'b0;
      tmo_evt = 1'b0;
      unique case (state_q)
         ST_IDLE:  if (start_i) state_d = ST_ARM;
         ST_ARM:   if (gap_cnt >= GAP_M1) state_d = ST_PICK;
         ST_PICK:  if (ph_cnt >= CSL_M1) state_d = ST_TRACK;
         ST_TRACK: if (ph_cnt >= CSH_M1 && acq_cnt >= need_m1) state_d = ST_HOLD;
         ST_HOLD:  if (ph_cnt >= CSL_M1) state_d = ST_WAIT;
         ST_WAIT: begin
            if (!eoc_n_i && ph_cnt >= CSH_M1) begin
               state_d = ST_READ;
            end else if (ph_cnt >= TMO_M1) begin
               state_d = ST_IDLE;
               tmo_evt = 1'b1;
            end
         end
         ST_READ: begin
            if (ph_cnt >= RD_M1) begin
               state_d = ST_IDLE;
               cap_evt = 1'b1;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   assign ph_clr  = (state_d != state_q);
   assign acq_clr = (state_d == ST_PICK) && (state_q != ST_PICK);
   assign gap_clr = cap_evt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         pd_q      <= 1'b0;
         bip_q     <= 1'b0;
         ref_off_q <= 1'b1;
         res_q     <= '0;
         valid_q   <= 1'b0;
         tmo_q     <= 1'b0;
      end else begin
         state_q <= state_d;
         valid_q <= cap_evt;
         tmo_q   <= tmo_evt;
         if (state_q == ST_IDLE && start_i) begin
            pd_q  <= shutdown_i;
            bip_q <= bipolar_i;
         end
         if (state_q == ST_TRACK && state_d == ST_HOLD) begin
            ref_off_q <= pd_q;
         end else if (tmo_evt) begin
            ref_off_q <= 1'b1;
         end
         if (cap_evt) begin
            res_q <= fmt_res;
         end
      end
   end

   always_comb begin
      cs_n_o = 1'b1;
      rc_o   = 1'b0;
      unique case (state_q)
         ST_PICK:  cs_n_o = 1'b0;
         ST_TRACK: rc_o   = pd_q;
         ST_HOLD: begin
            cs_n_o = 1'b0;
            rc_o   = pd_q;
         end
         ST_WAIT:  rc_o   = 1'b1;
         ST_READ: begin
            cs_n_o = 1'b0;
            rc_o   = 1'b1;
         end
         default: ;
      endcase
   end

   assign result_o  = res_q;
   assign valid_o   = valid_q;
   assign timeout_o = tmo_q;
   assign busy_o    = (state_q != ST_IDLE);

   // run length of the current chip-select level, kept for the width checks
   logic          cs_q;
   logic [RW-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q  <= 1'b1;
         run_q <= RUN_TOP;
      end else begin
         cs_q <= cs_n_o;
         if (cs_n_o != cs_q) begin
            run_q <= '0;
         end else if (run_q != RUN_TOP) begin
            run_q <= run_q + 1'b1;
         end
      end
   end

   assert_first_edge_rc_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n_o && cs_q && state_q == ST_PICK) |-> !rc_o);

   assert_cs_low_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n_o && !cs_q) |-> run_q >= RCSL_M1);

   assert_cs_high_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n_o && cs_q) |-> run_q >= RCSH_M1);

   assert_read_after_eoc_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_READ && $past(state_q) == ST_WAIT) |-> !$past(eoc_n_i));

   assert_strobe_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> !busy_o);

   assert_timeout_no_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_o |-> (!valid_o && $past(state_q) == ST_WAIT));

endmodule

// File: tb/tb_adc_read_ctrl.sv
module tb_adc_read_ctrl;

   localparam int DW     = 14;
   localparam int T_CSL  = 2;
   localparam int T_CSH  = 3;
   localparam int T_ACQ  = 10;
   localparam int T_WAKE = 40;
   localparam int T_DO   = 3;
   localparam int T_BR   = 5;
   localparam int T_TMO  = 30;
   localparam int T_CONV = 8;
   localparam int ACQ_OFF = (T_WAKE > T_ACQ) ? T_WAKE : T_ACQ;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic          rst_n, start_i, bipolar_i, shutdown_i, eoc_n_i;
   logic [DW-1:0] data_i;
   logic          cs_n_o, rc_o, valid_o, busy_o, timeout_o;
   logic [DW-1:0] result_o;

   adc_read_ctrl #(
      .DW(DW), .T_CSL(T_CSL), .T_CSH(T_CSH), .T_ACQ(T_ACQ), .T_WAKE(T_WAKE),
      .T_DO(T_DO), .T_BR(T_BR), .T_TMO(T_TMO)
   ) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .bipolar_i(bipolar_i),
      .shutdown_i(shutdown_i), .eoc_n_i(eoc_n_i), .data_i(data_i),
      .cs_n_o(cs_n_o), .rc_o(rc_o), .result_o(result_o), .valid_o(valid_o),
      .busy_o(busy_o), .timeout_o(timeout_o)
   );

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   int n_req = 0;
   bit done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // converter model
   logic          cs_prev = 1'b1;
   logic          valid_prev = 1'b0;
   int            idx = 0;
   int            e1_cyc = 0, e2_cyc = 0, rise_cyc = 0;
   int            low_cnt = 0, hi_cnt = 100;
   int            conv_left = -1;
   int            need = 0;
   int            n_edge1 = 0;
   bit            ref_off_m = 1'b1;
   bit            last_rd = 1'b0;
   bit            exp_pd = 1'b0;
   bit            no_eoc = 1'b0;
   logic [DW-1:0] code_m = '0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (cs_prev && !cs_n_o) begin
            chk(hi_cnt >= T_CSH, "R2 chip select high width", hi_cnt, T_CSH);
            if (idx == 1) begin
               idx = 2;
               e2_cyc = cyc;
               chk(rc_o == exp_pd, "R1 second edge mode level", int'(rc_o), int'(exp_pd));
               need = ref_off_m ? ACQ_OFF : T_ACQ;
               if (ref_off_m)
                  chk(cyc - e1_cyc == need, "R4 wake spacing", cyc - e1_cyc, need);
               else
                  chk(cyc - e1_cyc == need, "R3 acquisition spacing", cyc - e1_cyc, need);
               ref_off_m = rc_o;
               conv_left = T_CONV;
            end else if (!rc_o) begin
               idx = 1;
               e1_cyc = cyc;
               n_edge1++;
               if (last_rd)
                  chk(cyc - rise_cyc >= T_BR, "R6 bus release gap", cyc - rise_cyc, T_BR);
            end else if (idx == 2) begin
               idx = 3;
               chk(eoc_n_i == 1'b0, "R5 third edge after end of conversion", int'(eoc_n_i), 0);
            end else begin
               chk(1'b0, "R1 unexpected edge", idx, 0);
            end
            low_cnt = 0;
         end
         if (!cs_prev && cs_n_o) begin
            chk(low_cnt >= T_CSL, "R2 chip select low width", low_cnt, T_CSL);
            hi_cnt = 0;
            if (idx == 3) begin
               rise_cyc = cyc;
               last_rd = 1'b1;
               eoc_n_i = 1'b1;
               idx = 0;
            end
         end
         if (!cs_n_o) low_cnt++;
         else hi_cnt++;
         if (conv_left > 0) begin
            conv_left--;
            if (conv_left == 0 && !no_eoc) eoc_n_i = 1'b0;
         end
         if (timeout_o) begin
            ref_off_m = 1'b1;
            conv_left = -1;
         end
         data_i = (idx == 3 && !cs_n_o && low_cnt > T_DO) ? code_m : ~code_m;
         if (valid_o && valid_prev)
            chk(1'b0, "R8 strobe longer than one cycle", 2, 1);
         valid_prev = valid_o;
         cs_prev = cs_n_o;
      end
   end

   task automatic run_conv(input logic [DW-1:0] code, input bit bip, input bit pd, input bit poke);
      logic [DW-1:0] exp;
      int w;
      code_m = code;
      exp_pd = pd;
      bipolar_i = bip;
      shutdown_i = pd;
      start_i = 1'b1;
      n_req++;
      @(negedge clk);
      start_i = 1'b0;
      chk(busy_o == 1'b1, "R8 busy after start", int'(busy_o), 1);
      if (poke) begin
         repeat (3) @(negedge clk);
         start_i = 1'b1;
         bipolar_i = ~bip;
         shutdown_i = ~pd;
         @(negedge clk);
         start_i = 1'b0;
         bipolar_i = bip;
         shutdown_i = pd;
      end
      w = 0;
      while (!valid_o && !timeout_o && w < 3000) begin
         @(negedge clk);
         w++;
      end
      if (valid_o) begin
         exp = bip ? (code ^ 14'h2000) : code;
         if (bip)
            chk(result_o == exp, "R7 bipolar result", int'(result_o), int'(exp));
         else
            chk(result_o == exp, "R7 unipolar result", int'(result_o), int'(exp));
         chk(!busy_o && cs_n_o, "R8 busy low at strobe", int'(busy_o), 0);
      end else begin
         chk(1'b0, "R8 result strobe missing", w, 0);
      end
   endtask

   always @(posedge clk) begin
      if (cyc > 150000 && !done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      int w;
      rst_n = 1'b0;
      start_i = 1'b0;
      bipolar_i = 1'b0;
      shutdown_i = 1'b0;
      eoc_n_i = 1'b1;
      data_i = '0;
      repeat (3) @(negedge clk);
      chk(cs_n_o == 1'b1, "R11 reset chip select", int'(cs_n_o), 1);
      chk(busy_o == 1'b0, "R11 reset busy", int'(busy_o), 0);
      chk(valid_o == 1'b0, "R11 reset valid", int'(valid_o), 0);
      chk(timeout_o == 1'b0, "R11 reset timeout", int'(timeout_o), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // first frame after reset waits the wake window, then standby frames
      run_conv(14'h0ABC, 1'b0, 1'b0, 1'b0);
      run_conv(14'h1357, 1'b1, 1'b0, 1'b0);

      // sweep of codes, formats and power modes, back to back, with ignored starts
      for (int i = 0; i < 78; i++) begin
         run_conv(DW'((i * 211) % 16384), bit'(i % 2), (i % 4) == 3, (i % 3) == 1);
      end

      // format corners in both modes
      for (int m = 0; m < 2; m++) begin
         run_conv(14'h0000, bit'(m), 1'b0, 1'b0);
         run_conv(14'h0001, bit'(m), 1'b0, 1'b0);
         run_conv(14'h1FFF, bit'(m), 1'b0, 1'b0);
         run_conv(14'h2000, bit'(m), 1'b0, 1'b0);
         run_conv(14'h2001, bit'(m), 1'b1, 1'b0);
         run_conv(14'h3FFF, bit'(m), 1'b0, 1'b0);
      end

      // idle period, then a frame from rest
      repeat (20) @(negedge clk);
      run_conv(14'h2AAA, 1'b1, 1'b0, 1'b0);

      // R10: end of conversion never arrives
      no_eoc = 1'b1;
      code_m = 14'h1111;
      exp_pd = 1'b0;
      bipolar_i = 1'b0;
      shutdown_i = 1'b0;
      start_i = 1'b1;
      n_req++;
      @(negedge clk);
      start_i = 1'b0;
      w = 0;
      while (!timeout_o && w < 3000) begin
         @(negedge clk);
         w++;
      end
      chk(timeout_o == 1'b1, "R10 timeout raised", int'(timeout_o), 1);
      chk(cyc - e2_cyc == T_CSL + T_TMO, "R10 timeout instant", cyc - e2_cyc, T_CSL + T_TMO);
      chk(valid_o == 1'b0 && busy_o == 1'b0, "R10 no strobe and idle", int'(valid_o), 0);
      @(negedge clk);
      no_eoc = 1'b0;
      chk(timeout_o == 1'b0, "R10 timeout single pulse", int'(timeout_o), 0);
      // next frame must treat the reference as unpowered
      run_conv(14'h0F0F, 1'b0, 1'b0, 1'b0);
      run_conv(14'h3C3C, 1'b1, 1'b0, 1'b1);

      repeat (10) @(negedge clk);
      chk(n_edge1 == n_req, "R9 starts while busy ignored", n_edge1, n_req);
      chk(busy_o == 1'b0 && cs_n_o == 1'b1, "R9 no extra frame", int'(busy_o), 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule